// File: doc/BRIEF.md
# Two-Event Classification Sequence Detector

This block follows the physical-layer classification handshake that a power-sourcing port performs on its powered device. It reads an unsigned port-voltage code, sampled once per clock in 0.1 V steps, and sorts every sample into a voltage zone: low (the reset range and everything below it), mark, classification, power-on, or a neutral gap. A zone only counts as entered once the code has stayed inside it for a set number of consecutive samples. Single-sample and short glitches are therefore ignored.

A sequencer tracks the ordered pattern of classification finger, mark, second finger and second mark. When the voltage reaches the power-on level, the sequencer latches the source type. A source that showed the full two-pair pattern is type 2. Anything else, including a source that skipped classification, is type 1. Any qualified fall into the low zone throws away a sequence in progress and also clears a latched type.

The active-low type-2 indicator is driven low only when a type-2 source is latched and the downstream converter reports that it is powered. Otherwise the indicator stays released (high).

Top module: `pd_class_seq`

## Requirements
- R1: Zones use inclusive code bounds. Low is 0..53. Mark is 54..97. Classification is 130..205. Power-on is 400 and above. Codes 98..129 and 206..399 are a neutral gap that changes nothing.
- R2: A zone is entered only on the 4th consecutive sample inside it (parameter `DEB_N`, default 4). A stay of fewer samples has no effect on the sequence.
- R3: The type is latched as type 2 when the qualified order is classification, mark, classification, mark, followed by power-on.
- R4: The indicator is low only while type 2 is latched and `conv_pg` is high. It follows changes of `conv_pg` or of the latched type one clock edge after the edge that samples them.
- R5: Power-on after no classification, after a lone finger, or after only one finger-mark pair latches type 1. In these cases the indicator stays high whatever `conv_pg` does.
- R6: A qualified entry into the low zone clears a sequence in progress, for example between events. It also clears a latched type, so the indicator is released.
- R7: A third classification finger after two complete pairs makes the sequence invalid. Power-on then latches type 1.
- R8: Once a type is latched, qualified entries into the classification or mark zones leave the latched type unchanged.
- R9: While `rst_n` is low, the indicator is high and the sequence is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcode | input | 10 | Port voltage code, unsigned, 0.1 V per step |
| conv_pg | input | 1 | Downstream converter reports it is powered |
| type2_n | output | 1 | Active-low type-2 source indicator |

## Verification
The power-on qualification and a change of the converter flag can land on the same clock edge. In that case the indicator must still use the type held before that edge, and it must react one edge later. The bench provokes this directly by raising `conv_pg` just before the fourth power-on sample, and it expects the indicator to stay high for one cycle and then go low. Random episodes toggle the flag at random points inside the voltage holds, so the same collision, and its mirror with a low-zone clear, recur many times. A bench reference model judges each cycle.

// File: rtl/pd_cls_pkg.sv
package pd_cls_pkg;

  typedef enum logic [2:0] {Z_LOW, Z_MARK, Z_CLASS, Z_ON, Z_GAP} zone_e;

  typedef enum logic [2:0] {
    S_IDLE, S_F1, S_M1, S_F2, S_M2, S_BAD, S_PWR1, S_PWR2
  } seq_e;

  // Sort one code into its zone; all bounds inclusive.
  function automatic zone_e zone_of(input int unsigned c,
                                    input int unsigned low_hi,
                                    input int unsigned mrk_lo,
                                    input int unsigned mrk_hi,
                                    input int unsigned cls_lo,
                                    input int unsigned cls_hi,
                                    input int unsigned on_lvl);
    if (c >= on_lvl)                    return Z_ON;
    else if (c >= cls_lo && c <= cls_hi) return Z_CLASS;
    else if (c >= mrk_lo && c <= mrk_hi) return Z_MARK;
    else if (c <= low_hi)               return Z_LOW;
    else                                return Z_GAP;
  endfunction

  // Run length after one more sample, saturating at lim.
  function automatic int unsigned run_next(input int unsigned cnt,
                                           input bit same,
                                           input int unsigned lim);
    if (!same)       return 1;
    else if (cnt >= lim) return lim;
    else             return cnt + 1;
  endfunction

  // Sequencer step on a qualified zone entry.
  function automatic seq_e seq_step(input seq_e s, input zone_e z);
    seq_e n;
    n = s;
    case (z)
      Z_LOW: n = S_IDLE;
      Z_CLASS: begin
        case (s)
          S_IDLE:  n = S_F1;
          S_M1:    n = S_F2;
          S_M2:    n = S_BAD;
          default: n = s;
        endcase
      end
      Z_MARK: begin
        case (s)
          S_F1:    n = S_M1;
          S_F2:    n = S_M2;
          default: n = s;
        endcase
      end
      Z_ON: begin
        case (s)
          S_PWR1, S_PWR2: n = s;
          S_M2:           n = S_PWR2;
          default:        n = S_PWR1;
        endcase
      end
      default: n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pd_zone_filter.sv
module pd_zone_filter
  import pd_cls_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned LOW_HI = 53,
  parameter int unsigned MRK_LO = 54,
  parameter int unsigned MRK_HI = 97,
  parameter int unsigned CLS_LO = 130,
  parameter int unsigned CLS_HI = 205,
  parameter int unsigned ON_LVL = 400,
  parameter int unsigned DEB_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              ent,
  output zone_e             ent_zone
);
  localparam int unsigned CNT_W = $clog2(DEB_N + 1);

  zone_e            zone_now;
  zone_e            last_zone;
  logic [CNT_W-1:0] run;
  logic             same;
  int unsigned      nxt;

  always_comb begin
    zone_now = zone_of(32'(code), LOW_HI, MRK_LO, MRK_HI, CLS_LO, CLS_HI, ON_LVL);
    same     = (zone_now == last_zone);
    nxt      = run_next(32'(run), same, DEB_N);
    ent      = (nxt == DEB_N) && !(same && (32'(run) == DEB_N));
    ent_zone = zone_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= '0;
      last_zone <= Z_GAP;
    end else begin
      run       <= CNT_W'(nxt);
      last_zone <= zone_now;
    end
  end

  generate
    if (DEB_N > 1) begin : g_deb_chk
      // R2
      deb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent |-> ($past(zone_now) == zone_now));
    end
  endgenerate

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_cls_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ent,
  input  zone_e ent_zone,
  output seq_e  state
);
  seq_e state_d;

  always_comb begin
    state_d = ent ? seq_step(state, ent_zone) : state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_d;
  end

  // R6
  low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent && ent_zone == Z_LOW) |=> (state == S_IDLE));

  // R8
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent && ent_zone != Z_LOW && (state == S_PWR1 || state == S_PWR2))
      |=> $stable(state));

  // R3
  pwr2_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PWR2 && $past(state) != S_PWR2) |-> ($past(state) == S_M2));

endmodule

// File: rtl/pd_ind_drive.sv
module pd_ind_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic is_t2,
  input  logic conv_pg,
  output logic type2_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) type2_n <= 1'b1;
    else        type2_n <= ~(is_t2 & conv_pg);
  end

  // R4
  ind_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(type2_n) |-> $past(is_t2 && conv_pg));

  // R4
  ind_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_pg |=> type2_n);

endmodule

// File: rtl/pd_class_seq.sv
module pd_class_seq
  import pd_cls_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned MRK_LO = 54,
  parameter int unsigned MRK_HI = 97,
  parameter int unsigned CLS_LO = 130,
  parameter int unsigned CLS_HI = 205,
  parameter int unsigned ON_LVL = 400,
  parameter int unsigned DEB_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vcode,
  input  logic              conv_pg,
  output logic              type2_n
);
  localparam int unsigned LOW_HI = MRK_LO - 1;

  logic  ent;
  zone_e ent_zone;
  seq_e  state;
  logic  is_t2;

  pd_zone_filter #(
    .CODE_W(CODE_W), .LOW_HI(LOW_HI), .MRK_LO(MRK_LO), .MRK_HI(MRK_HI),
    .CLS_LO(CLS_LO), .CLS_HI(CLS_HI), .ON_LVL(ON_LVL), .DEB_N(DEB_N)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .code(vcode), .ent(ent), .ent_zone(ent_zone)
  );

  pd_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ent(ent), .ent_zone(ent_zone), .state(state)
  );

  assign is_t2 = (state == S_PWR2);

  pd_ind_drive u_ind (
    .clk(clk), .rst_n(rst_n), .is_t2(is_t2), .conv_pg(conv_pg), .type2_n(type2_n)
  );

endmodule

// File: tb/pd_class_seq_tb.sv
module pd_class_seq_tb;
  localparam int DEB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] vcode = '0;
  logic       conv_pg = 1'b0;
  logic       type2_n;

  int n_chk = 0;
  int n_fail = 0;
  bit rnd_on = 0;

  always #5 clk = ~clk;

  pd_class_seq u_dut (
    .clk(clk), .rst_n(rst_n), .vcode(vcode), .conv_pg(conv_pg), .type2_n(type2_n)
  );

  // Bench zone ids: 0 low, 1 mark, 2 class, 3 power-on, 4 gap
  function automatic int bzone(input int c);
    if (c <= 53)       return 0;
    else if (c <= 97)  return 1;
    else if (c < 130)  return 4;
    else if (c <= 205) return 2;
    else if (c < 400)  return 4;
    else               return 3;
  endfunction

  function automatic int pick(input int z);
    case (z)
      0: return int'($urandom_range(0, 53));
      1: return int'($urandom_range(54, 97));
      2: return int'($urandom_range(130, 205));
      3: return int'($urandom_range(400, 700));
      default: return ($urandom_range(0, 1) == 1) ? int'($urandom_range(98, 129))
                                                  : int'($urandom_range(206, 399));
    endcase
  endfunction

  // Reference model: steps 0..4 count the alternating events
  int   m_last = 4, m_run = 0, m_steps = 0, m_lat = 0;
  bit   m_bad = 0;
  logic m_out = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_last = 4; m_run = 0; m_steps = 0; m_lat = 0; m_bad = 0; m_out = 1'b1;
    end else begin
      int z, r;
      bit q;
      z = bzone(int'(vcode));
      r = (z == m_last) ? ((m_run >= DEB) ? DEB : m_run + 1) : 1;
      q = (r == DEB) && !(z == m_last && m_run == DEB);
      m_out = !(m_lat == 2 && conv_pg);
      if (q) begin
        if (z == 0) begin
          m_steps = 0; m_bad = 0; m_lat = 0;
        end else if (m_lat == 0) begin
          if (z == 3) m_lat = (m_steps == 4 && !m_bad) ? 2 : 1;
          else if (z == 2) begin
            if (m_steps == 0 || m_steps == 2) m_steps++;
            else if (m_steps == 4) m_bad = 1;
          end else if (z == 1) begin
            if (m_steps == 1 || m_steps == 3) m_steps++;
          end
        end
      end
      m_last = z;
      m_run = r;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: type2_n=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic hold(input int code, input int n);
    vcode = 10'(code);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rnd_on) chk(type2_n, m_out, "random R3/R5/R6/R7 model");
    end
  endtask

  task automatic pattern(input int f1, input int mk1, input int f2, input int mk2, input int len);
    hold(f1, len); hold(115, 2); hold(mk1, len); hold(115, 2);
    hold(f2, len); hold(115, 2); hold(mk2, len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: expired, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7301));
    repeat (3) @(negedge clk);
    chk(type2_n, 1'b1, "R9 in reset");
    rst_n = 1'b1;
    hold(20, 6);
    chk(type2_n, 1'b1, "R9 after reset");

    // R3: full two-pair pattern then power-on with converter up
    conv_pg = 1'b1;
    pattern(160, 70, 180, 60, 6);
    hold(450, 8);
    chk(type2_n, 1'b0, "R3 two-event type 2");

    // R4: converter drop and return, one edge latency
    conv_pg = 1'b0;
    #1 chk(type2_n, 1'b0, "R4 before edge");
    @(negedge clk);
    chk(type2_n, 1'b1, "R4 released after flag drop");
    conv_pg = 1'b1;
    @(negedge clk);
    chk(type2_n, 1'b0, "R4 asserted after flag rise");

    // R8: dips into class and mark zones keep the type
    hold(170, 8); hold(70, 8); hold(450, 6);
    chk(type2_n, 1'b0, "R8 latched type held");

    // R6: low zone clears latched type; R5: power without classification
    hold(30, 6);
    chk(type2_n, 1'b1, "R6 low clears latched");
    hold(450, 8);
    chk(type2_n, 1'b1, "R5 classification skipped");

    // R5: single finger-mark pair
    hold(20, 6);
    hold(150, 6); hold(80, 6); hold(450, 8);
    chk(type2_n, 1'b1, "R5 single event");

    // R6: reset-window code 53 between events
    hold(20, 6);
    hold(150, 6); hold(80, 6); hold(53, 6);
    hold(150, 6); hold(80, 6); hold(450, 8);
    chk(type2_n, 1'b1, "R6 reset between events");

    // R2: second finger only 3 samples long is not counted
    hold(20, 6);
    hold(150, 6); hold(80, 6); hold(150, 3); hold(80, 6); hold(450, 8);
    chk(type2_n, 1'b1, "R2 short finger ignored");

    // R2 boundary + R1 inclusive edges: exactly 4 samples each
    hold(20, 6);
    hold(130, 4); hold(97, 4); hold(205, 4); hold(54, 4);
    hold(399, 8);
    chk(type2_n, 1'b1, "R1 code 399 not power-on");
    hold(400, 6);
    chk(type2_n, 1'b0, "R1 R2 edge codes type 2");

    // R1: gap codes just outside windows do not count
    hold(20, 6);
    pattern(206, 98, 129, 98, 6);
    hold(450, 8);
    chk(type2_n, 1'b1, "R1 gap codes ignored");

    // R7: third finger invalidates
    hold(20, 6);
    pattern(160, 70, 180, 60, 6);
    hold(170, 6); hold(60, 6); hold(450, 8);
    chk(type2_n, 1'b1, "R7 third finger");

    // R4: power-on qualification and flag rise on the same edge
    hold(20, 6);
    conv_pg = 1'b0;
    pattern(160, 70, 180, 60, 5);
    hold(450, 3);
    conv_pg = 1'b1;
    @(negedge clk);
    chk(type2_n, 1'b1, "R4 same-edge uses old type");
    @(negedge clk);
    chk(type2_n, 1'b0, "R4 same-edge next cycle");

    // R9: reset while powered
    rst_n = 1'b0;
    @(negedge clk);
    chk(type2_n, 1'b1, "R9 reset while powered");
    rst_n = 1'b1;
    hold(20, 6);

    // Random episodes judged by the model
    rnd_on = 1;
    for (int e = 0; e < 120; e++) begin
      int kind;
      kind = int'($urandom_range(0, 3));
      conv_pg = 1'($urandom_range(0, 1));
      hold(pick(0), int'($urandom_range(3, 8)));
      for (int s = 0; s < 4 + kind; s++) begin
        int z;
        if (kind == 0) z = (s % 2 == 0) ? 2 : 1;
        else           z = int'($urandom_range(0, 4));
        hold(pick(z), (kind == 0) ? int'($urandom_range(4, 8)) : int'($urandom_range(1, 8)));
        if ($urandom_range(0, 3) == 0) conv_pg = ~conv_pg;
      end
      hold(pick(3), int'($urandom_range(2, 8)));
      conv_pg = 1'($urandom_range(0, 1));
      hold(pick(3), int'($urandom_range(3, 10)));
      conv_pg = ~conv_pg;
      hold(pick(3), int'($urandom_range(1, 6)));
    end
    rnd_on = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule